// File: doc/BRIEF.md
# Rank Refresh Sequencer

This block keeps one DRAM rank refreshed on a fixed period. Once it is armed, an interval counter marks a refresh as due every `cfg_interval_i` cycles. When a refresh is due, the sequencer withdraws the rank from the request scheduler by pulling the available flag low. It then waits until the count of in-flight accesses reaches zero. Next it closes every bank with a one-cycle precharge-all strobe, unless the banks are already closed. After that it issues a one-cycle refresh strobe and holds the rank unavailable for the refresh duration.

The refresh period runs independently of how long each refresh sequence takes. A slow drain delays one refresh but does not move the next due point. A start pulse arms the interval counter, and a stop pulse disarms it. Bank state tracking and power-down decisions belong to neighbouring logic.

Top module: `rank_refresh_sched`

## Requirements
- R1: While reset is asserted and right after it is released, `avail_o` is 1, `pre_all_o` and `refresh_o` are 0, and the interval counter is disarmed.
- R2: No refresh happens until `start_i` has been sampled high. If `start_i` is sampled at clock edge E, `avail_o` goes low on the cycle `cfg_interval_i + 1` edges after E.
- R3: After `avail_o` falls, the sequencer stays in its drain phase for as long as `inflight_i` is nonzero. It leaves drain on the edge after the first cycle with `inflight_i == 0`. `avail_o` stays low from the start of drain until the refresh duration has ended.
- R4: If `banks_closed_i` is 0 on the first cycle after drain, `pre_all_o` is high for exactly that one cycle.
- R5: If `banks_closed_i` is 1 on that cycle, no precharge-all is issued, and `refresh_o` is asserted on the next cycle.
- R6: After a precharge-all, `refresh_o` is asserted exactly `cfg_trp_i` cycles later. A value of 0 counts as 1.
- R7: `avail_o` returns high exactly `cfg_trfc_i` cycles after the refresh strobe. A value of 0 counts as 1.
- R8: Due points fall every `cfg_interval_i` cycles after arming, independent of drain and refresh length. The second fall of `avail_o` comes `2*cfg_interval_i + 1` edges after the start edge.
- R9: `stop_i` disarms the counter and clears any pending refresh, and no later refresh starts. When `stop_i` and `start_i` are sampled together, stop takes priority.
- R10: Each refresh sequence issues exactly one refresh strobe. `pre_all_o` and `refresh_o` are single-cycle, never high together, and never high while `avail_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Arms the interval counter; the first refresh falls due one interval later |
| stop_i | input | 1 | Disarms the counter and drops any pending refresh |
| cfg_interval_i | input | IVL_W | Refresh period in cycles |
| cfg_trp_i | input | TIM_W | Cycles from precharge-all to the refresh strobe |
| cfg_trfc_i | input | TIM_W | Cycles from the refresh strobe back to available |
| inflight_i | input | CNT_W | Number of accesses still in flight on the rank |
| banks_closed_i | input | 1 | All banks of the rank are already precharged |
| pre_all_o | output | 1 | One-cycle precharge-all command strobe |
| refresh_o | output | 1 | One-cycle refresh command strobe |
| avail_o | output | 1 | Rank may accept new requests |

## Verification
The main sequence is run with five settings. These cover open banks and closed banks, drains of zero to five cycles, and precharge-to-refresh gaps of one to five cycles. The closed-bank vectors separate the skipped-precharge path from the normal one. The nonzero-drain vectors show that the in-flight count, and not a fixed delay, releases the drain. Checking the second due point after a long drain exposes any slip in the period. Separate runs with no start pulse, with a stop before the due point, and with stop and start together show that scheduling stays silent whenever it is not armed.

// File: rtl/rref_pkg.sv
package rref_pkg;
  typedef enum logic [1:0] {
    RS_IDLE  = 2'd0,
    RS_DRAIN = 2'd1,
    RS_PRE   = 2'd2,
    RS_RUN   = 2'd3
  } rref_state_e;
endpackage

// File: rtl/rref_interval_timer.sv
// Free-running period counter: due points are spaced by the interval,
// independent of how long each refresh takes.
module rref_interval_timer #(
  parameter int IVL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [IVL_W-1:0] cfg_interval_i,
  input  logic             take_i,
  output logic             pending_o
);
  localparam logic [IVL_W-1:0] ONE = IVL_W'(1);

  logic             armed_q, armed_d;
  logic [IVL_W-1:0] cnt_q, cnt_d;
  logic             pend_q, pend_d;
  logic [IVL_W-1:0] limit;
  logic             due;
  logic             cnt_en;

  always_comb begin
    limit  = (cfg_interval_i == '0) ? '0 : (cfg_interval_i - ONE);
    due    = armed_q && (cnt_q == limit);
    armed_d = armed_q;
    cnt_d   = cnt_q;
    pend_d  = pend_q;
    if (stop_i) begin
      armed_d = 1'b0;
      cnt_d   = '0;
      pend_d  = 1'b0;
    end else if (start_i) begin
      armed_d = 1'b1;
      cnt_d   = '0;
      pend_d  = pend_q && !take_i;
    end else begin
      if (armed_q) cnt_d = due ? '0 : (cnt_q + ONE);
      if (due)         pend_d = 1'b1;
      else if (take_i) pend_d = 1'b0;
    end
    cnt_en = stop_i || start_i || armed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      armed_q <= armed_d;
      pend_q  <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign pending_o = pend_q;
endmodule

// File: rtl/rref_wait_cnt.sv
// Shared down-counter for the precharge and refresh waits.
module rref_wait_cnt #(
  parameter int TIM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [TIM_W-1:0] load_val_i,
  output logic [TIM_W-1:0] cnt_o
);
  localparam logic [TIM_W-1:0] ONE = TIM_W'(1);

  logic [TIM_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = load_i ? load_val_i : (cnt_q - ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rref_seq_fsm.sv
module rref_seq_fsm
  import rref_pkg::*;
#(
  parameter int TIM_W = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pending_i,
  input  logic [CNT_W-1:0] inflight_i,
  input  logic             banks_closed_i,
  input  logic [TIM_W-1:0] cfg_trp_i,
  input  logic [TIM_W-1:0] cfg_trfc_i,
  input  logic [TIM_W-1:0] wait_cnt_i,
  output logic             take_o,
  output logic             pre_all_o,
  output logic             refresh_o,
  output logic             avail_o,
  output logic             load_o,
  output logic [TIM_W-1:0] load_val_o,
  output rref_state_e      state_o,
  output logic             first_o
);
  localparam logic [TIM_W-1:0] ONE = TIM_W'(1);

  rref_state_e state_q, state_d;
  logic        first_q, first_d;
  logic        wait_done;

  always_comb begin
    state_d    = state_q;
    take_o     = 1'b0;
    pre_all_o  = 1'b0;
    refresh_o  = 1'b0;
    load_o     = 1'b0;
    load_val_o = '0;
    wait_done  = (wait_cnt_i <= ONE);
    unique case (state_q)
      RS_IDLE: begin
        if (pending_i) begin
          take_o  = 1'b1;
          state_d = RS_DRAIN;
        end
      end
      RS_DRAIN: begin
        if (inflight_i == '0) state_d = RS_PRE;
      end
      RS_PRE: begin
        if (first_q) begin
          if (banks_closed_i) begin
            state_d = RS_RUN;
          end else begin
            pre_all_o  = 1'b1;
            load_o     = 1'b1;
            load_val_o = (cfg_trp_i == '0) ? '0 : (cfg_trp_i - ONE);
            if (cfg_trp_i <= ONE) state_d = RS_RUN;
          end
        end else if (wait_done) begin
          state_d = RS_RUN;
        end
      end
      RS_RUN: begin
        if (first_q) begin
          refresh_o  = 1'b1;
          load_o     = 1'b1;
          load_val_o = (cfg_trfc_i == '0) ? '0 : (cfg_trfc_i - ONE);
          if (cfg_trfc_i <= ONE) state_d = RS_IDLE;
        end else if (wait_done) begin
          state_d = RS_IDLE;
        end
      end
      default: state_d = RS_IDLE;
    endcase
    first_d = (state_d != state_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RS_IDLE;
      first_q <= 1'b0;
    end else begin
      state_q <= state_d;
      first_q <= first_d;
    end
  end

  assign avail_o = (state_q == RS_IDLE);
  assign state_o = state_q;
  assign first_o = first_q;
endmodule

// File: rtl/rank_refresh_sched.sv
module rank_refresh_sched
  import rref_pkg::*;
#(
  parameter int IVL_W = 16,
  parameter int TIM_W = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [IVL_W-1:0] cfg_interval_i,
  input  logic [TIM_W-1:0] cfg_trp_i,
  input  logic [TIM_W-1:0] cfg_trfc_i,
  input  logic [CNT_W-1:0] inflight_i,
  input  logic             banks_closed_i,
  output logic             pre_all_o,
  output logic             refresh_o,
  output logic             avail_o
);
  logic             due_pending;
  logic             take;
  logic             wait_load;
  logic [TIM_W-1:0] wait_val;
  logic [TIM_W-1:0] wait_cnt;
  rref_state_e      seq_state;
  logic             seq_first;

  rref_interval_timer #(.IVL_W(IVL_W)) u_timer (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .stop_i         (stop_i),
    .cfg_interval_i (cfg_interval_i),
    .take_i         (take),
    .pending_o      (due_pending)
  );

  rref_wait_cnt #(.TIM_W(TIM_W)) u_wait (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (wait_load),
    .load_val_i (wait_val),
    .cnt_o      (wait_cnt)
  );

  rref_seq_fsm #(.TIM_W(TIM_W), .CNT_W(CNT_W)) u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .pending_i      (due_pending),
    .inflight_i     (inflight_i),
    .banks_closed_i (banks_closed_i),
    .cfg_trp_i      (cfg_trp_i),
    .cfg_trfc_i     (cfg_trfc_i),
    .wait_cnt_i     (wait_cnt),
    .take_o         (take),
    .pre_all_o      (pre_all_o),
    .refresh_o      (refresh_o),
    .avail_o        (avail_o),
    .load_o         (wait_load),
    .load_val_o     (wait_val),
    .state_o        (seq_state),
    .first_o        (seq_first)
  );
endmodule

// File: rtl/rank_refresh_sched_chk.sv
module rank_refresh_sched_chk
  import rref_pkg::*;
#(
  parameter int TIM_W = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stop_i,
  input logic [CNT_W-1:0] inflight_i,
  input logic             banks_closed_i,
  input logic [TIM_W-1:0] cfg_trp_i,
  input logic [TIM_W-1:0] cfg_trfc_i,
  input logic             pre_all_o,
  input logic             refresh_o,
  input logic             avail_o,
  input rref_state_e      st,
  input logic             first,
  input logic             pending
);
  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(pre_all_o && refresh_o));

  assert_quiet_when_avail_R10: assert property (@(posedge clk) disable iff (!rst_n)
    avail_o |-> (!pre_all_o && !refresh_o));

  assert_ref_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_o |=> !refresh_o);

  assert_pre_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pre_all_o |=> !pre_all_o);

  assert_drain_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RS_DRAIN && inflight_i != '0) |=> (st == RS_DRAIN && !avail_o));

  assert_closed_skip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RS_PRE && first && banks_closed_i) |=> refresh_o);

  assert_trp_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_all_o && cfg_trp_i > TIM_W'(1)) |=> !refresh_o);

  assert_trfc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_o && cfg_trfc_i > TIM_W'(1)) |=> !avail_o);

  assert_stop_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> !pending);
endmodule

bind rank_refresh_sched rank_refresh_sched_chk #(.TIM_W(TIM_W), .CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .stop_i         (stop_i),
  .inflight_i     (inflight_i),
  .banks_closed_i (banks_closed_i),
  .cfg_trp_i      (cfg_trp_i),
  .cfg_trfc_i     (cfg_trfc_i),
  .pre_all_o      (pre_all_o),
  .refresh_o      (refresh_o),
  .avail_o        (avail_o),
  .st             (seq_state),
  .first          (seq_first),
  .pending        (due_pending)
);

// File: tb/rank_refresh_sched_tb.sv
module rank_refresh_sched_tb;
  localparam int IVL_W = 16;
  localparam int TIM_W = 8;
  localparam int CNT_W = 4;

  // columns: interval, trp, trfc, banks_closed, drain_len, expected refresh offset
  localparam int NV = 5;
  localparam int VT [NV][6] = '{
    '{20, 3, 5, 0, 0, 25},
    '{16, 4, 6, 1, 0, 19},
    '{30, 2, 8, 0, 5, 39},
    '{12, 1, 1, 0, 2, 17},
    '{25, 5, 3, 1, 4, 32}
  };

  logic             clk;
  logic             rst_n;
  logic             start_i, stop_i;
  logic [IVL_W-1:0] cfg_interval_i;
  logic [TIM_W-1:0] cfg_trp_i, cfg_trfc_i;
  logic [CNT_W-1:0] inflight_i;
  logic             banks_closed_i;
  logic             pre_all_o, refresh_o, avail_o;

  int nchk, nerr;
  bit done;

  rank_refresh_sched #(.IVL_W(IVL_W), .TIM_W(TIM_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .cfg_interval_i(cfg_interval_i), .cfg_trp_i(cfg_trp_i), .cfg_trfc_i(cfg_trfc_i),
    .inflight_i(inflight_i), .banks_closed_i(banks_closed_i),
    .pre_all_o(pre_all_o), .refresh_o(refresh_o), .avail_o(avail_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string rq, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  task automatic settle();
    @(negedge clk);
    stop_i = 1'b1;
    inflight_i = '0;
    banks_closed_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    for (int w = 0; w < 100 && !avail_o; w++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic run_vec(input int i);
    int iv, trp, trfc, dl, fall1, fall2, rise1, pre_k, ref_k, npre, nref, both;
    bit pa;
    iv = VT[i][0]; trp = VT[i][1]; trfc = VT[i][2]; dl = VT[i][4];
    cfg_interval_i = IVL_W'(iv);
    cfg_trp_i = TIM_W'(trp);
    cfg_trfc_i = TIM_W'(trfc);
    banks_closed_i = VT[i][3][0];
    inflight_i = CNT_W'(3);
    fall1 = -1; fall2 = -1; rise1 = -1; pre_k = -1; ref_k = -1;
    npre = 0; nref = 0; both = 0;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    pa = avail_o;
    for (int k = 0; k <= 2 * iv + 1; k++) begin
      inflight_i = (k < iv + 1 + dl) ? CNT_W'(3) : '0;
      if (!avail_o && pa) begin
        if (fall1 < 0) fall1 = k;
        else if (fall2 < 0) fall2 = k;
      end
      if (avail_o && !pa && rise1 < 0) rise1 = k;
      if (pre_all_o) begin npre++; if (pre_k < 0) pre_k = k; end
      if (refresh_o) begin nref++; if (ref_k < 0) ref_k = k; end
      if ((pre_all_o && refresh_o) || (avail_o && (pre_all_o || refresh_o))) both++;
      pa = avail_o;
      @(negedge clk);
    end
    chk("R2 avail fall offset", fall1, iv + 1);
    if (VT[i][3] != 0) begin
      chk("R5 no precharge when closed", npre, 0);
    end else begin
      chk("R4 one precharge", npre, 1);
      chk("R3 R4 precharge offset", pre_k, iv + 2 + dl);
    end
    chk("R6 R5 R3 refresh offset", ref_k, VT[i][5]);
    chk("R7 avail return", rise1, VT[i][5] + ((trfc < 1) ? 1 : trfc));
    chk("R8 second due", fall2, 2 * iv + 1);
    chk("R10 one refresh", nref, 1);
    chk("R10 strobe exclusivity", both, 0);
    settle();
  endtask

  initial begin
    int cnt_ref, cnt_low;
    nchk = 0; nerr = 0; done = 1'b0;
    rst_n = 1'b0; start_i = 1'b0; stop_i = 1'b0;
    cfg_interval_i = IVL_W'(10); cfg_trp_i = TIM_W'(2); cfg_trfc_i = TIM_W'(3);
    inflight_i = '0; banks_closed_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 avail in reset", int'(avail_o), 1);
    chk("R1 strobes in reset", int'(pre_all_o) + int'(refresh_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 avail after reset", int'(avail_o), 1);

    // R2: never armed -> never refreshes
    cnt_ref = 0; cnt_low = 0;
    for (int k = 0; k < 200; k++) begin
      if (refresh_o || pre_all_o) cnt_ref++;
      if (!avail_o) cnt_low++;
      @(negedge clk);
    end
    chk("R2 no refresh before start", cnt_ref, 0);
    chk("R2 avail held before start", cnt_low, 0);

    for (int i = 0; i < NV; i++) run_vec(i);

    // R9: stop before the first due point
    cfg_interval_i = IVL_W'(10);
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    repeat (4) @(negedge clk);
    stop_i = 1'b1;
    @(negedge clk) stop_i = 1'b0;
    cnt_ref = 0; cnt_low = 0;
    for (int k = 0; k < 40; k++) begin
      if (refresh_o || pre_all_o) cnt_ref++;
      if (!avail_o) cnt_low++;
      @(negedge clk);
    end
    chk("R9 no refresh after stop", cnt_ref, 0);
    chk("R9 avail held after stop", cnt_low, 0);

    // R9: stop wins over a simultaneous start
    start_i = 1'b1; stop_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; stop_i = 1'b0;
    cnt_low = 0;
    for (int k = 0; k < 40; k++) begin
      if (!avail_o || refresh_o) cnt_low++;
      @(negedge clk);
    end
    chk("R9 stop priority", cnt_low, 0);

    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end
endmodule